// File: doc/BRIEF.md
# Control Endpoint Status Handshake Register

This block holds the firmware-visible control and status byte of the default control endpoint in a USB device controller. Firmware reaches it through a simple byte-wide CPU write port and a registered read image. A protocol engine on the other side reports what happens on the bus with one-cycle event pulses: a received data packet placed in the FIFO, a control transfer that ended early, an IN packet that went out, a STALL handshake that went out, and a completed status stage.

In the other direction the block hands the engine three levels: a stall request, an IN-packet-ready flag and a data-end flag. It also produces a FIFO flush pulse when a control transfer ends early, and a sticky endpoint interrupt flag that is gated by an enable input and cleared by a strobe. Every bit has its own set, clear and self-clear rule. Status bits that firmware cannot write directly are cleared through dedicated command bits that never read back as 1. When a hardware set and a firmware clear meet in one cycle, the hardware set wins.

Top module: `ctl_ep_csr`

## Requirements
- R1: After reset the read image is 0x00, and the stall request, IN-ready, data-end, flush and interrupt outputs are all 0.
- R2: An early-end event sets the early-end status (bit 4) and drives a one-cycle FIFO flush pulse in the following cycle. Writing 1 to bit 7 clears bit 4. A write to bit 4 itself has no effect.
- R3: A received-packet event sets the received status (bit 0). Writing 1 to bit 6 clears it. A write to bit 0 itself has no effect.
- R4: Bits 7 and 6 are command bits: they act only on the write cycle and always read as 0.
- R5: Writing 1 to bit 5 raises the stall request (read back on bit 5). It drops on its own when the stall-sent event arrives.
- R6: The stall-sent event sets bit 2. Bit 2 stays set until firmware writes 0 to it. A write with bit 2 at 1 leaves it set.
- R7: Writing 1 to bit 1 raises IN-ready (read back on bit 1). The IN-sent event clears it.
- R8: Writing 1 to bit 3 raises data-end (read back on bit 3), together with IN-ready or with the bit 6 command when firmware needs to. The status-done event clears it.
- R9: When a hardware set event and a firmware clear of the same bit fall in one cycle, the bit ends up set.
- R10: Each of the early-end, received-packet, IN-sent and stall-sent events sets a sticky interrupt flag. The interrupt output equals that flag ANDed with the enable, registered. The clear strobe clears the flag, but a new event in the same cycle keeps it set.
- R11: The read image is registered: it shows the state that was present one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Registered read image of the register |
| ev_early_end | input | 1 | Control transfer ended prematurely |
| ev_rx_pkt | input | 1 | Received data packet placed in FIFO |
| ev_in_sent | input | 1 | IN packet transmitted |
| ev_stall_sent | input | 1 | STALL handshake transmitted |
| ev_status_done | input | 1 | Status stage completed |
| eng_stall_req | output | 1 | Request to answer with STALL |
| eng_in_ready | output | 1 | An IN packet is loaded and ready |
| eng_data_end | output | 1 | Last data packet has been handled |
| fifo_flush | output | 1 | One-cycle FIFO flush pulse |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Interrupt flag clear strobe |
| irq | output | 1 | Endpoint interrupt request |

## Verification
The hardest case to reach from the ports is a collision: a hardware event that sets a status bit lands in the same clock as a firmware write that clears that bit. The same applies to the interrupt flag when an event meets the clear strobe. To create these cases, the bench raises the event pulse and the write strobe, or the clear strobe, at the same falling edge so that both are sampled by one rising edge. It then reads the image back to confirm the bit survived.

// File: rtl/ctl_ep_pkg.sv
package ctl_ep_pkg;
  localparam int CSR_W = 8;
  // bit positions are decoded by firmware, so they are fixed
  localparam int B_CLR_EARLY = 7;
  localparam int B_CLR_RX    = 6;
  localparam int B_STALL_REQ = 5;
  localparam int B_EARLY_END = 4;
  localparam int B_DATA_END  = 3;
  localparam int B_STALL_OUT = 2;
  localparam int B_IN_RDY    = 1;
  localparam int B_RX_RDY    = 0;
  localparam int NUM_IRQ_SRC = 4;

  typedef struct packed {
    logic clr_early;
    logic clr_rx;
    logic set_stall;
    logic set_data_end;
    logic clr_stall_out;
    logic set_in_rdy;
  } csr_cmd_t;

  typedef struct packed {
    logic stall_req;
    logic early_end;
    logic data_end;
    logic stall_out;
    logic in_rdy;
    logic rx_rdy;
  } csr_state_t;
endpackage

// File: rtl/ctl_ep_cmd_dec.sv
module ctl_ep_cmd_dec
  import ctl_ep_pkg::*;
(
  input  logic             wr,
  input  logic [CSR_W-1:0] wdata,
  output csr_cmd_t         cmd
);
  // read-only positions are deliberately ignored
  logic unused_ro;
  assign unused_ro = ^{wdata[B_EARLY_END], wdata[B_RX_RDY]};

  always_comb begin
    cmd.clr_early     = wr & wdata[B_CLR_EARLY];
    cmd.clr_rx        = wr & wdata[B_CLR_RX];
    cmd.set_stall     = wr & wdata[B_STALL_REQ];
    cmd.set_data_end  = wr & wdata[B_DATA_END];
    cmd.clr_stall_out = wr & ~wdata[B_STALL_OUT];
    cmd.set_in_rdy    = wr & wdata[B_IN_RDY];
  end
endmodule

// File: rtl/ctl_ep_state.sv
module ctl_ep_state
  import ctl_ep_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  csr_cmd_t   cmd,
  input  logic       ev_early_end,
  input  logic       ev_rx_pkt,
  input  logic       ev_in_sent,
  input  logic       ev_stall_sent,
  input  logic       ev_status_done,
  output csr_state_t st,
  output logic       flush
);
  csr_state_t st_nxt;

  always_comb begin
    // hardware set wins over firmware clear
    st_nxt.early_end = ev_early_end  | (st.early_end & ~cmd.clr_early);
    st_nxt.rx_rdy    = ev_rx_pkt     | (st.rx_rdy    & ~cmd.clr_rx);
    st_nxt.stall_out = ev_stall_sent | (st.stall_out & ~cmd.clr_stall_out);
    // firmware set wins over hardware self-clear
    st_nxt.stall_req = cmd.set_stall    | (st.stall_req & ~ev_stall_sent);
    st_nxt.in_rdy    = cmd.set_in_rdy   | (st.in_rdy    & ~ev_in_sent);
    st_nxt.data_end  = cmd.set_data_end | (st.data_end  & ~ev_status_done);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= '0;
      flush <= 1'b0;
    end else begin
      st    <= st_nxt;
      flush <= ev_early_end;
    end
  end

  // R2
  early_set_chk: assert property (@(posedge clk) disable iff (rst)
    ev_early_end |=> (st.early_end && flush));
  // R9
  rx_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_rx_pkt && cmd.clr_rx) |=> st.rx_rdy);
  // R5
  stall_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_stall_sent && !cmd.set_stall) |=> (!st.stall_req && st.stall_out));
  // R6
  stall_out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st.stall_out && !cmd.clr_stall_out) |=> st.stall_out);
  // R7
  in_rdy_set_chk: assert property (@(posedge clk) disable iff (rst)
    cmd.set_in_rdy |=> st.in_rdy);
  // R8
  data_end_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_status_done && !cmd.set_data_end) |=> !st.data_end);
endmodule

// File: rtl/ctl_ep_irq.sv
module ctl_ep_irq #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src,
  input  logic            en,
  input  logic            clr,
  output logic            irq
);
  logic pend, pend_nxt;

  assign pend_nxt = (|src) | (pend & ~clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      irq  <= 1'b0;
    end else begin
      pend <= pend_nxt;
      irq  <= pend_nxt & en;
    end
  end

  // R10
  irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (|src) |=> pend);
  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !irq);
endmodule

// File: rtl/ctl_ep_csr.sv
module ctl_ep_csr
  import ctl_ep_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_wr,
  input  logic [CSR_W-1:0] cpu_wdata,
  output logic [CSR_W-1:0] cpu_rdata,
  input  logic             ev_early_end,
  input  logic             ev_rx_pkt,
  input  logic             ev_in_sent,
  input  logic             ev_stall_sent,
  input  logic             ev_status_done,
  output logic             eng_stall_req,
  output logic             eng_in_ready,
  output logic             eng_data_end,
  output logic             fifo_flush,
  input  logic             irq_en,
  input  logic             irq_clr,
  output logic             irq
);
  csr_cmd_t   cmd;
  csr_state_t st;
  logic [CSR_W-1:0] image;

  ctl_ep_cmd_dec u_dec (
    .wr    (cpu_wr),
    .wdata (cpu_wdata),
    .cmd   (cmd)
  );

  ctl_ep_state u_state (
    .clk            (clk),
    .rst            (rst),
    .cmd            (cmd),
    .ev_early_end   (ev_early_end),
    .ev_rx_pkt      (ev_rx_pkt),
    .ev_in_sent     (ev_in_sent),
    .ev_stall_sent  (ev_stall_sent),
    .ev_status_done (ev_status_done),
    .st             (st),
    .flush          (fifo_flush)
  );

  ctl_ep_irq #(.NSRC(NUM_IRQ_SRC)) u_irq (
    .clk (clk),
    .rst (rst),
    .src ({ev_early_end, ev_rx_pkt, ev_in_sent, ev_stall_sent}),
    .en  (irq_en),
    .clr (irq_clr),
    .irq (irq)
  );

  always_comb begin
    image = '0;
    image[B_STALL_REQ] = st.stall_req;
    image[B_EARLY_END] = st.early_end;
    image[B_DATA_END]  = st.data_end;
    image[B_STALL_OUT] = st.stall_out;
    image[B_IN_RDY]    = st.in_rdy;
    image[B_RX_RDY]    = st.rx_rdy;
  end

  always_ff @(posedge clk) begin
    if (rst) cpu_rdata <= '0;
    else     cpu_rdata <= image;
  end

  assign eng_stall_req = st.stall_req;
  assign eng_in_ready  = st.in_rdy;
  assign eng_data_end  = st.data_end;

  // R4
  cmd_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_rdata[B_CLR_EARLY] == 1'b0) && (cpu_rdata[B_CLR_RX] == 1'b0));
  // R11
  rdata_lag_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(eng_in_ready) |=> cpu_rdata[B_IN_RDY]);
endmodule

// File: tb/ctl_ep_csr_bench.sv
`timescale 1ns/1ps
module ctl_ep_csr_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpu_wr = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic ev_early_end = 0, ev_rx_pkt = 0, ev_in_sent = 0, ev_stall_sent = 0, ev_status_done = 0;
  logic eng_stall_req, eng_in_ready, eng_data_end, fifo_flush;
  logic irq_en = 0, irq_clr = 0, irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ctl_ep_csr u_ctl_ep_csr (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .ev_early_end(ev_early_end), .ev_rx_pkt(ev_rx_pkt), .ev_in_sent(ev_in_sent),
    .ev_stall_sent(ev_stall_sent), .ev_status_done(ev_status_done),
    .eng_stall_req(eng_stall_req), .eng_in_ready(eng_in_ready), .eng_data_end(eng_data_end),
    .fifo_flush(fifo_flush), .irq_en(irq_en), .irq_clr(irq_clr), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    cpu_wr = 1'b1; cpu_wdata = v;
    tick;
    cpu_wr = 1'b0; cpu_wdata = '0;
  endtask

  // image lags state by one clock
  task automatic rd_chk(input string req, input logic [7:0] exp);
    tick;
    chk(req, cpu_rdata, exp);
  endtask

  task automatic t_reset;
    chk("R1 rdata", cpu_rdata, 8'h00);
    chk("R1 outputs", {3'b0, eng_stall_req, eng_in_ready, eng_data_end, fifo_flush, irq}, 8'h00);
  endtask

  task automatic t_early_end;
    ev_early_end = 1; tick; ev_early_end = 0;
    chk("R2 flush pulse", {7'b0, fifo_flush}, 8'h01);
    tick;
    chk("R2 flush ends", {7'b0, fifo_flush}, 8'h00);
    chk("R11 R2 early end set", cpu_rdata, 8'h10);
    wr(8'h10);
    rd_chk("R2 write to bit4 ignored", 8'h10);
    wr(8'h80);
    rd_chk("R2 R4 clear via bit7", 8'h00);
  endtask

  task automatic t_rx;
    ev_rx_pkt = 1; tick; ev_rx_pkt = 0;
    rd_chk("R3 rx set", 8'h01);
    wr(8'h01);
    rd_chk("R3 write to bit0 ignored", 8'h01);
    wr(8'hC0);
    rd_chk("R3 R4 clear via bit6", 8'h00);
  endtask

  task automatic t_stall;
    wr(8'h20);
    chk("R5 stall req raised", {7'b0, eng_stall_req}, 8'h01);
    rd_chk("R5 stall readback", 8'h20);
    ev_stall_sent = 1; tick; ev_stall_sent = 0;
    chk("R5 stall req drops", {7'b0, eng_stall_req}, 8'h00);
    rd_chk("R6 stall sent set", 8'h04);
    wr(8'h04);
    rd_chk("R6 write 1 keeps bit2", 8'h04);
    wr(8'h00);
    rd_chk("R6 write 0 clears bit2", 8'h00);
  endtask

  task automatic t_in_data_end;
    wr(8'h0A);
    chk("R7 R8 engine levels", {6'b0, eng_in_ready, eng_data_end}, 8'h03);
    rd_chk("R7 R8 readback", 8'h0A);
    ev_in_sent = 1; tick; ev_in_sent = 0;
    chk("R7 in ready cleared", {7'b0, eng_in_ready}, 8'h00);
    rd_chk("R8 data end held", 8'h08);
    ev_status_done = 1; tick; ev_status_done = 0;
    chk("R8 data end cleared", {7'b0, eng_data_end}, 8'h00);
    rd_chk("R8 readback clear", 8'h00);
  endtask

  task automatic t_collide;
    ev_rx_pkt = 1; cpu_wr = 1; cpu_wdata = 8'h40;
    tick;
    ev_rx_pkt = 0; cpu_wr = 0; cpu_wdata = 0;
    rd_chk("R9 rx set beats clear", 8'h01);
    ev_stall_sent = 1; cpu_wr = 1; cpu_wdata = 8'h40;
    tick;
    ev_stall_sent = 0; cpu_wr = 0; cpu_wdata = 0;
    rd_chk("R9 stall sent beats clear", 8'h04);
    wr(8'h00);
    rd_chk("R9 cleanup", 8'h00);
  endtask

  task automatic t_irq;
    irq_en = 0; irq_clr = 1; tick; irq_clr = 0;
    ev_in_sent = 1; tick; ev_in_sent = 0;
    chk("R10 disabled irq low", {7'b0, irq}, 8'h00);
    irq_en = 1; tick;
    chk("R10 enable exposes flag", {7'b0, irq}, 8'h01);
    irq_clr = 1; tick; irq_clr = 0;
    chk("R10 clear drops irq", {7'b0, irq}, 8'h00);
    ev_early_end = 1; irq_clr = 1; tick; ev_early_end = 0; irq_clr = 0;
    chk("R10 event beats clear", {7'b0, irq}, 8'h01);
    wr(8'h80);
    irq_clr = 1; tick; irq_clr = 0;
    chk("R10 cleared again", {7'b0, irq}, 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    tick;
    t_reset;
    t_early_end;
    t_rx;
    t_stall;
    t_in_data_end;
    t_collide;
    t_irq;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule